// File: doc/BRIEF.md
# Reader Mode Sequencer With Serial Mode Register

This block is the phase controller of an inductive tag reader. A host drives one control line, active low, and that line does three jobs. In Idle, short low pulses program a 7-bit mode register. A long low pulse starts the carrier Charge phase. While writing, the line's level gates the carrier directly. The sequencer also steps through Sleep and Wake on its own, and ends a Read after a delayed stop request or after a time limit.

The block decodes the mode register into four results: a carrier division factor, a synchronous-output flag, a threshold-source select and a test flag. One code of the factor field hands the factor over to a measured value, and 119 is used when no valid measurement is present. Outputs are the current phase and the enables for the antenna bridge, the demodulator and the serial encoder. All timings are parameters counted in cycles of the block clock. The defaults assume a 16 MHz clock. The line is assumed to be synchronous to the clock.

Top module: `reader_seq`

## Requirements
- R1: After reset the phase is Idle and the bridge, demodulator and encoder enables are low. The mode register is zero, so the factor is 119 and all flags are low. Phase codes are Idle=0, Sleep=1, Wake=2, Charge=3, Write=4, Recharge=5, Read=6. An illegal state code returns to Idle.
- R2: In Idle, Charge is entered at the clock edge that samples the line low for the T_CHARGE-th consecutive time. In Charge the bridge and encoder enables are high.
- R3: In Charge without synchronous mode, the rising edge of the line ends the low run. If the run was shorter than T_WSEL samples the next phase is Read, with the demodulator and encoder enabled and the bridge off. Otherwise the next phase is Write.
- R4: In Idle, Sleep is entered at the edge that samples the line high for the T_SLEEP-th consecutive time. In Sleep all enables are low.
- R5: In Sleep, any low sample moves to Wake. Wake lasts exactly T_WAKE cycles, ignores the line, and then returns to Idle.
- R6: In Read, a low run is counted from its first low sample as edge 1. If it lasts at least T_MINLOW samples, Read ends at edge T_RDSTOP+1 even if the line has risen again in between. Shorter low runs have no effect.
- R7: A Read phase lasts at most T_READ cycles and then returns to Idle.
- R8: In Idle, each low pulse is one bit: 1 if it lasts more than T_ONE samples, else 0. The first pulse of a session is a start bit and is discarded. The next seven are shifted in in order, code bit 0 to 3, then sync (register bit 4), threshold select (bit 5) and test (bit 6). The register changes only when the seventh bit arrives. A partial session is dropped when Idle is left.
- R9: The factor decodes from the 4-bit code as follows: 0 gives 119; 1 to 11 give 113 plus the code; 12 to 14 give 119; 15 gives the measured factor when it is marked valid and 119 otherwise.
- R10: In Write, the bridge enable follows the line one cycle later. A low run of T_CHARGE samples moves to Recharge, where the bridge is on, and the next rising edge moves to Read.
- R11: In synchronous mode, Charge ignores the line. It moves to Read only once T_SYNC cycles have passed in Charge and a diagnostic-sent pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| host_line | input | 1 | Host control line, active low |
| diag_sent | input | 1 | Pulse: diagnostic byte has been sent |
| meas_valid | input | 1 | Measured factor is valid |
| meas_div | input | 8 | Measured division factor |
| phase_o | output | 3 | Current phase code |
| bridge_en | output | 1 | Antenna bridge carrier enable |
| demod_en | output | 1 | Demodulator enable |
| enc_en | output | 1 | Serial encoder enable |
| div_factor | output | 8 | Decoded carrier division factor |
| sync_mode | output | 1 | Synchronous serial output selected |
| afc_sel | output | 1 | Threshold taken from the code field |
| test_flag | output | 1 | Test flag from the register |

## Verification
The line is driven with several kinds of low pulse, and each kind targets one distinction. Pulse lengths on both sides of each threshold check that the bit-value, charge-entry, write-select and stop-request limits fall on the stated sample. Lows applied during Wake, during synchronous Charge and as short Read glitches show that the line is ignored in those states. Register sessions with manual, boundary, reserved and automatic codes, with and without a valid measurement, separate the decode branches. A session abandoned into Charge shows that partial writes are dropped.

// File: rtl/reader_seq_pkg.sv
package reader_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SLEEP    = 3'd1,
        PH_WAKE     = 3'd2,
        PH_CHARGE   = 3'd3,
        PH_WRITE    = 3'd4,
        PH_RECHARGE = 3'd5,
        PH_READ     = 3'd6
    } phase_e;

    localparam int MODE_W          = 7;
    localparam int CODE_W          = 4;
    localparam int DIV_W           = 8;
    localparam int DIV_DEFAULT     = 119;
    localparam int DIV_BASE        = 113;
    localparam int CODE_MANUAL_MAX = 11;
    localparam int CODE_AUTO       = 15;

    typedef struct packed {
        logic              test;
        logic              afc;
        logic              sync;
        logic [CODE_W-1:0] code;
    } mode_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DIV_W-1:0] decode_div(
        input logic [CODE_W-1:0] code,
        input logic              mv,
        input logic [DIV_W-1:0]  md
    );
        if (code == CODE_W'(CODE_AUTO))
            return mv ? md : DIV_W'(DIV_DEFAULT);
        else if (code != '0 && code <= CODE_W'(CODE_MANUAL_MAX))
            return DIV_W'(DIV_BASE) + DIV_W'(code);
        else
            return DIV_W'(DIV_DEFAULT);
    endfunction

endpackage

// File: rtl/rs_run_counter.sv
module rs_run_counter #(
    parameter int CNT_W = 8,
    parameter bit LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    output logic [CNT_W-1:0] run
);
    // consecutive samples at LEVEL, saturating
    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (line != LEVEL)
            run <= '0;
        else if (run != '1)
            run <= run + 1'b1;
    end
endmodule

// File: rtl/rs_mode_reg.sv
module rs_mode_reg
    import reader_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_ONE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_idle,
    input  logic             line,
    input  logic [CNT_W-1:0] lo_run,
    output mode_t            mode
);
    localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(T_ONE);

    logic [2:0]        idx;
    logic [MODE_W-1:0] shreg;
    logic              rise;
    logic              bit_val;
    logic [MODE_W-1:0] shifted;

    assign rise    = line && (lo_run != '0);
    assign bit_val = lo_run > LIM_ONE;
    assign shifted = {bit_val, shreg[MODE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            shreg <= '0;
            mode  <= '0;
        end else if (!in_idle) begin
            idx <= '0;
        end else if (rise) begin
            if (idx == 3'd0) begin
                idx <= 3'd1;           // start bit, discarded
            end else if (idx == 3'(MODE_W)) begin
                mode <= mode_t'(shifted);
                idx  <= '0;
            end else begin
                shreg <= shifted;
                idx   <= idx + 3'd1;
            end
        end
    end
endmodule

// File: rtl/rs_phase_fsm.sv
module rs_phase_fsm
    import reader_seq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int T_CHARGE = 12,
    parameter int T_WSEL   = 40,
    parameter int T_SYNC   = 30,
    parameter int T_SLEEP  = 60,
    parameter int T_WAKE   = 10,
    parameter int T_READ   = 80,
    parameter int T_RDSTOP = 20,
    parameter int T_MINLOW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic [CNT_W-1:0] lo_run,
    input  logic [CNT_W-1:0] hi_run,
    input  logic             sync_mode,
    input  logic             diag_sent,
    output phase_e           phase
);
    localparam logic [CNT_W-1:0] LIM_CHG  = CNT_W'(T_CHARGE - 1);
    localparam logic [CNT_W-1:0] LIM_WSEL = CNT_W'(T_WSEL);
    localparam logic [CNT_W-1:0] LIM_SYNC = CNT_W'(T_SYNC - 1);
    localparam logic [CNT_W-1:0] LIM_SLP  = CNT_W'(T_SLEEP - 1);
    localparam logic [CNT_W-1:0] LIM_WAKE = CNT_W'(T_WAKE - 1);
    localparam logic [CNT_W-1:0] LIM_READ = CNT_W'(T_READ - 1);
    localparam logic [CNT_W-1:0] LIM_STOP = CNT_W'(T_RDSTOP);
    localparam logic [CNT_W-1:0] LIM_MINL = CNT_W'(T_MINLOW - 1);
    localparam bit               ARM_NOW  = (T_MINLOW <= 1);

    phase_e           nxt;
    logic [CNT_W-1:0] tmr;
    logic             diag_seen;
    logic             rd_pend;
    logic             rd_arm;
    logic [CNT_W-1:0] rd_dly;
    logic             rise;

    assign rise = line && (lo_run != '0);

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: begin
                if (!line && lo_run >= LIM_CHG)
                    nxt = PH_CHARGE;
                else if (line && hi_run >= LIM_SLP)
                    nxt = PH_SLEEP;
            end
            PH_SLEEP: begin
                if (!line)
                    nxt = PH_WAKE;
            end
            PH_WAKE: begin
                if (tmr >= LIM_WAKE)
                    nxt = PH_IDLE;
            end
            PH_CHARGE: begin
                if (sync_mode) begin
                    if (tmr >= LIM_SYNC && (diag_seen || diag_sent))
                        nxt = PH_READ;
                end else if (rise) begin
                    nxt = (lo_run >= LIM_WSEL) ? PH_WRITE : PH_READ;
                end
            end
            PH_WRITE: begin
                if (!line && lo_run >= LIM_CHG)
                    nxt = PH_RECHARGE;
            end
            PH_RECHARGE: begin
                if (rise)
                    nxt = PH_READ;
            end
            PH_READ: begin
                if (tmr >= LIM_READ)
                    nxt = PH_IDLE;
                else if (rd_pend && rd_arm && rd_dly >= LIM_STOP)
                    nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
        end else begin
            phase <= nxt;
            if (nxt != phase)
                tmr <= '0;
            else if (tmr != '1)
                tmr <= tmr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || phase != PH_CHARGE)
            diag_seen <= 1'b0;
        else if (diag_sent)
            diag_seen <= 1'b1;
    end

    // delayed stop request while reading
    always_ff @(posedge clk) begin
        if (rst || phase != PH_READ || nxt != PH_READ) begin
            rd_pend <= 1'b0;
            rd_arm  <= 1'b0;
            rd_dly  <= '0;
        end else if (!rd_pend) begin
            if (!line) begin
                rd_pend <= 1'b1;
                rd_dly  <= CNT_W'(1);
                rd_arm  <= ARM_NOW;
            end
        end else begin
            if (rd_dly != '1)
                rd_dly <= rd_dly + 1'b1;
            if (!line && lo_run >= LIM_MINL)
                rd_arm <= 1'b1;
            if (line && !rd_arm) begin
                rd_pend <= 1'b0;
                rd_dly  <= '0;
            end
        end
    end
endmodule

// File: rtl/reader_seq.sv
module reader_seq
    import reader_seq_pkg::*;
#(
    parameter int T_ONE    = 3200,
    parameter int T_CHARGE = 16000,
    parameter int T_WSEL   = 1120000,
    parameter int T_SYNC   = 48000,
    parameter int T_SLEEP  = 1600000,
    parameter int T_WAKE   = 32000,
    parameter int T_READ   = 320000,
    parameter int T_RDSTOP = 14400,
    parameter int T_MINLOW = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_line,
    input  logic             diag_sent,
    input  logic             meas_valid,
    input  logic [DIV_W-1:0] meas_div,
    output logic [2:0]       phase_o,
    output logic             bridge_en,
    output logic             demod_en,
    output logic             enc_en,
    output logic [DIV_W-1:0] div_factor,
    output logic             sync_mode,
    output logic             afc_sel,
    output logic             test_flag
);
    localparam int unsigned T_MAX = max2(max2(max2(T_SLEEP, T_READ), max2(T_WSEL, T_SYNC)),
                                         max2(max2(T_WAKE, T_RDSTOP), max2(T_CHARGE, T_ONE)));
    localparam int CNT_W = $clog2(T_MAX + 2);

    logic [CNT_W-1:0] runs [2];
    logic [CNT_W-1:0] lo_run;
    logic [CNT_W-1:0] hi_run;
    phase_e           phase;
    mode_t            mode;
    logic [MODE_W-1:0] mode_bits;

    // index 0 counts low samples, index 1 high samples
    for (genvar g = 0; g < 2; g++) begin : g_run
        rs_run_counter #(.CNT_W(CNT_W), .LEVEL(g[0])) u_run (
            .clk  (clk),
            .rst  (rst),
            .line (host_line),
            .run  (runs[g])
        );
    end
    assign lo_run = runs[0];
    assign hi_run = runs[1];

    rs_mode_reg #(.CNT_W(CNT_W), .T_ONE(T_ONE)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .in_idle (phase == PH_IDLE),
        .line    (host_line),
        .lo_run  (lo_run),
        .mode    (mode)
    );

    rs_phase_fsm #(
        .CNT_W(CNT_W), .T_CHARGE(T_CHARGE), .T_WSEL(T_WSEL), .T_SYNC(T_SYNC),
        .T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE), .T_READ(T_READ),
        .T_RDSTOP(T_RDSTOP), .T_MINLOW(T_MINLOW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .line      (host_line),
        .lo_run    (lo_run),
        .hi_run    (hi_run),
        .sync_mode (mode.sync),
        .diag_sent (diag_sent),
        .phase     (phase)
    );

    assign mode_bits  = mode;
    assign phase_o    = phase;
    assign bridge_en  = (phase == PH_CHARGE) || (phase == PH_RECHARGE) ||
                        ((phase == PH_WRITE) && (lo_run == '0));
    assign demod_en   = (phase == PH_READ);
    assign enc_en     = (phase == PH_CHARGE) || (phase == PH_RECHARGE) || (phase == PH_READ);
    assign div_factor = decode_div(mode.code, meas_valid, meas_div);
    assign sync_mode  = mode.sync;
    assign afc_sel    = mode.afc;
    assign test_flag  = mode.test;
endmodule

// File: rtl/reader_seq_chk.sv
module reader_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_line,
    input logic [2:0] phase_o,
    input logic       bridge_en,
    input logic       demod_en,
    input logic       enc_en,
    input logic [7:0] div_factor,
    input logic [3:0] code
);
    p_phase_legal_r1: assert property (@(posedge clk) disable iff (rst)
        phase_o != 3'd7);

    p_charge_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd3 && $past(phase_o) != 3'd3) |-> ($past(phase_o) == 3'd0 && !$past(host_line)));

    p_read_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(demod_en) |-> ($past(phase_o) == 3'd3 || $past(phase_o) == 3'd5));

    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd1 && $past(phase_o) != 3'd1) |-> ($past(phase_o) == 3'd0 && $past(host_line)));

    p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd1) |-> (!bridge_en && !enc_en && !demod_en));

    p_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd1 && !host_line) |=> (phase_o == 3'd2));

    p_div_manual_r9: assert property (@(posedge clk) disable iff (rst)
        (code != 4'd15) |-> (div_factor >= 8'd114 && div_factor <= 8'd124));

    p_write_follow_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd4 && $past(phase_o) == 3'd4) |-> (bridge_en == $past(host_line)));
endmodule

bind reader_seq reader_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_line  (host_line),
    .phase_o    (phase_o),
    .bridge_en  (bridge_en),
    .demod_en   (demod_en),
    .enc_en     (enc_en),
    .div_factor (div_factor),
    .code       (mode_bits[3:0])
);

// File: tb/reader_seq_test.sv
module reader_seq_test;
    localparam int CLK_PERIOD = 62;
    localparam int T_ONE    = 4;
    localparam int T_CHARGE = 12;
    localparam int T_WSEL   = 40;
    localparam int T_SYNC   = 30;
    localparam int T_SLEEP  = 60;
    localparam int T_WAKE   = 10;
    localparam int T_READ   = 80;
    localparam int T_RDSTOP = 20;
    localparam int T_MINLOW = 6;

    localparam int IDLE = 0, SLEEP = 1, WAKE = 2, CHARGE = 3, WRITE = 4, RECHARGE = 5, READ = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_line = 1'b1;
    logic       diag_sent = 1'b0;
    logic       meas_valid = 1'b0;
    logic [7:0] meas_div = 8'd0;
    logic [2:0] phase_o;
    logic       bridge_en, demod_en, enc_en, sync_mode, afc_sel, test_flag;
    logic [7:0] div_factor;

    always #(CLK_PERIOD/2) clk = ~clk;

    reader_seq #(
        .T_ONE(T_ONE), .T_CHARGE(T_CHARGE), .T_WSEL(T_WSEL), .T_SYNC(T_SYNC),
        .T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE), .T_READ(T_READ),
        .T_RDSTOP(T_RDSTOP), .T_MINLOW(T_MINLOW)
    ) uut (
        .clk(clk), .rst(rst), .host_line(host_line), .diag_sent(diag_sent),
        .meas_valid(meas_valid), .meas_div(meas_div), .phase_o(phase_o),
        .bridge_en(bridge_en), .demod_en(demod_en), .enc_en(enc_en),
        .div_factor(div_factor), .sync_mode(sync_mode), .afc_sel(afc_sel),
        .test_flag(test_flag)
    );

    typedef enum {F_PHASE, F_BRIDGE, F_DEMOD, F_ENC, F_DIV, F_SYNC, F_AFC, F_TEST} field_e;
    typedef struct {
        string  req;
        field_e f;
        int     exp;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    event  chk_ev;

    function automatic int actual(field_e f);
        case (f)
            F_PHASE:  return int'(phase_o);
            F_BRIDGE: return int'(bridge_en);
            F_DEMOD:  return int'(demod_en);
            F_ENC:    return int'(enc_en);
            F_DIV:    return int'(div_factor);
            F_SYNC:   return int'(sync_mode);
            F_AFC:    return int'(afc_sel);
            default:  return int'(test_flag);
        endcase
    endfunction

    task automatic drain();
        while (sb.size() > 0) begin
            item_t it = sb.pop_front();
            int got = actual(it.f);
            total++;
            if (got != it.exp) begin
                bad++;
                $display("FAIL %s %s got=%0d exp=%0d", it.req, it.f.name(), got, it.exp);
            end
        end
    endtask

    // monitor: compares queued expectations with the live outputs
    initial forever begin
        @(chk_ev);
        drain();
    end

    task automatic expect_val(string req, field_e f, int v);
        sb.push_back('{req, f, v});
    endtask

    task automatic commit();
        -> chk_ev;
        #1;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_reg(logic [6:0] v);
        host_line = 1'b0; step(2); host_line = 1'b1; step(3);
        for (int i = 0; i < 7; i++) begin
            host_line = 1'b0;
            step(v[i] ? 8 : 2);
            host_line = 1'b1;
            step(3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog got=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        expect_val("R1", F_PHASE, IDLE);  expect_val("R1", F_BRIDGE, 0);
        expect_val("R1", F_DEMOD, 0);     expect_val("R1", F_ENC, 0);
        expect_val("R1", F_DIV, 119);     expect_val("R1", F_SYNC, 0);
        expect_val("R1", F_AFC, 0);       expect_val("R1", F_TEST, 0);
        commit();

        // R2 charge entry on the T_CHARGE-th low sample
        host_line = 1'b0;
        step(T_CHARGE - 1);
        expect_val("R2", F_PHASE, IDLE); commit();
        step(1);
        expect_val("R2", F_PHASE, CHARGE); expect_val("R2", F_BRIDGE, 1);
        expect_val("R2", F_ENC, 1); commit();
        step(20 - T_CHARGE);
        host_line = 1'b1;
        step(1);
        // R3 short charge goes to Read
        expect_val("R3", F_PHASE, READ); expect_val("R3", F_DEMOD, 1);
        expect_val("R3", F_BRIDGE, 0); expect_val("R3", F_ENC, 1); commit();

        // R6 short glitch ignored
        host_line = 1'b0; step(3); host_line = 1'b1;
        step(T_RDSTOP + 5);
        expect_val("R6", F_PHASE, READ); commit();
        // R6 delayed stop
        host_line = 1'b0;
        step(T_RDSTOP);
        expect_val("R6", F_PHASE, READ); commit();
        step(1);
        expect_val("R6", F_PHASE, IDLE); commit();
        step(1);
        expect_val("R2", F_PHASE, CHARGE); commit();
        host_line = 1'b1;
        step(1);
        expect_val("R3", F_PHASE, READ); commit();

        // R7 read time limit
        step(T_READ - 1);
        expect_val("R7", F_PHASE, READ); commit();
        step(1);
        expect_val("R7", F_PHASE, IDLE); commit();
        step(1);
        expect_val("R4", F_PHASE, SLEEP); expect_val("R4", F_BRIDGE, 0);
        expect_val("R4", F_ENC, 0); commit();

        // R5 wake, line ignored during wake
        host_line = 1'b0; step(1);
        expect_val("R5", F_PHASE, WAKE); commit();
        host_line = 1'b1; step(2);
        host_line = 1'b0; step(2);
        host_line = 1'b1; step(T_WAKE - 5);
        expect_val("R5", F_PHASE, WAKE); commit();
        step(1);
        expect_val("R5", F_PHASE, IDLE); commit();

        // R4 sleep timing: highs start at k=5
        step(T_SLEEP + 3 - T_WAKE);
        expect_val("R4", F_PHASE, IDLE); commit();
        step(1);
        expect_val("R4", F_PHASE, SLEEP); commit();
        host_line = 1'b0; step(1); host_line = 1'b1; step(T_WAKE);
        expect_val("R5", F_PHASE, IDLE); commit();

        // R8 / R9 programming and decode
        send_reg(7'b000_0101);
        expect_val("R9", F_DIV, 118); expect_val("R8", F_SYNC, 0);
        expect_val("R8", F_AFC, 0); expect_val("R8", F_TEST, 0); commit();
        send_reg(7'b000_1011);
        expect_val("R9", F_DIV, 124); commit();
        send_reg(7'b000_1100);
        expect_val("R9", F_DIV, 119); commit();
        send_reg(7'b000_1111);
        expect_val("R9", F_DIV, 119); commit();
        meas_valid = 1'b1; meas_div = 8'd121; step(1);
        expect_val("R9", F_DIV, 121); commit();
        send_reg(7'b111_0001);
        expect_val("R9", F_DIV, 114); expect_val("R8", F_SYNC, 1);
        expect_val("R8", F_AFC, 1); expect_val("R8", F_TEST, 1); commit();
        send_reg(7'b010_0101);
        expect_val("R8", F_DIV, 118); expect_val("R8", F_SYNC, 0);
        expect_val("R8", F_AFC, 1); expect_val("R8", F_TEST, 0); commit();

        // R8 partial session dropped; long charge selects Write (R3)
        host_line = 1'b0; step(2); host_line = 1'b1; step(3);
        for (int i = 0; i < 2; i++) begin
            host_line = 1'b0; step(8); host_line = 1'b1; step(3);
        end
        host_line = 1'b0; step(45);
        expect_val("R8", F_PHASE, CHARGE); expect_val("R8", F_DIV, 118);
        expect_val("R8", F_AFC, 1); commit();
        host_line = 1'b1; step(1);
        expect_val("R3", F_PHASE, WRITE); expect_val("R10", F_BRIDGE, 1); commit();

        // R10 write modulation and recharge
        host_line = 1'b0; step(1);
        expect_val("R10", F_BRIDGE, 0); commit();
        step(2); host_line = 1'b1; step(1);
        expect_val("R10", F_BRIDGE, 1); expect_val("R10", F_PHASE, WRITE); commit();
        host_line = 1'b0; step(T_CHARGE - 1);
        expect_val("R10", F_PHASE, WRITE); commit();
        step(1);
        expect_val("R10", F_PHASE, RECHARGE); expect_val("R10", F_BRIDGE, 1); commit();
        host_line = 1'b1; step(1);
        expect_val("R10", F_PHASE, READ); commit();
        step(T_READ);
        expect_val("R7", F_PHASE, IDLE); commit();
        step(1);
        host_line = 1'b0; step(1); host_line = 1'b1; step(T_WAKE);
        expect_val("R5", F_PHASE, IDLE); commit();

        // R11 synchronous mode charge exit
        send_reg(7'b001_0000);
        expect_val("R11", F_SYNC, 1); expect_val("R9", F_DIV, 119); commit();
        host_line = 1'b0; step(T_CHARGE);
        expect_val("R11", F_PHASE, CHARGE); commit();
        host_line = 1'b1; step(T_SYNC + 2);
        expect_val("R11", F_PHASE, CHARGE); commit();
        diag_sent = 1'b1; step(1); diag_sent = 1'b0;
        expect_val("R11", F_PHASE, READ); commit();

        drain();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule